// File: doc/BRIEF.md
# Paged Audio Controller Register Bank

This block is the software-visible register bank of a three-channel audio controller that has two playback channels and one record channel. A host reaches it through an 8-bit offset on a simple request/response bus. Every access carries a size code and byte-lane strobes, so the host can read and write single bytes, halfwords or full words. The bank holds the control, status, page, codec and serial-control words, three sample-count registers and six per-channel frame registers. The frame registers lie in a paged space that the host reaches through a window of sixteen offsets.

The channel engines report the end of a transfer block with one-cycle pulses. The bank turns each pulse into a per-channel pending flag, but only when software has enabled that channel's interrupt. The pending flags combine into a summary status bit and an interrupt line. When software clears an interrupt enable, the bank also clears that channel's pending flag, so a disabled channel never holds the interrupt line high.

Top module: `audio_regbank`

## Requirements
- R1: After reset, a word read returns 0x00000001 at control (0x00), 0x00000060 at status (0x04), and 0 at page (0x0C), codec (0x10) and serial control (0x20).
- R2: A write to control or serial control updates only the bytes whose strobe bit is set (strobe bit k selects wdata[8k+7:8k]). The other bytes keep their values.
- R3: The page register keeps only bits 3:0 of the written data. After a word write of 0xFFFFFFFF it reads back 0xF.
- R4: An offset in 0x30–0x3F becomes {page, offset}. Page 0xC gives playback-1 address and count at 0x30/0x34 and playback-2 address and count at 0x38/0x3C. Page 0xD gives record address and count at 0x30/0x34. The slots 0x38 and 0x3C on page 0xD, and every other page, ignore writes and read as all ones.
- R5: A read of any undecoded offset returns 0xFFFFFFFF. The one exception is a byte read of offset 0x1B, which returns 5.
- R6: Status bit 31 and irq_o are both 1 exactly when at least one pending bit is set. The pending bits are status[2] for playback 1, status[1] for playback 2 and status[0] for record.
- R7: A pulse on chan_done (bit 2 playback 1, bit 1 playback 2, bit 0 record) sets the matching pending bit only while its enable is 1. The enables are serial-control bit 8 for playback 1, bit 9 for playback 2 and bit 10 for record.
- R8: A serial-control write that takes an enable from 1 to 0 clears the matching pending bit. If a pulse for that channel arrives in the same cycle, the pending bit stays set.
- R9: The sample-count registers at 0x24, 0x28 and 0x2C store only bits 15:0 of the written data. Bits 31:16 read as 0.
- R10: A read is accepted on req_valid. rsp_valid is high for exactly the next cycle, and rsp_data holds the addressed bytes shifted down to bit 0 and masked to the size. The size codes are 0 for byte, 1 for halfword and 2 for word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Always 1; every request is accepted in the cycle it is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_strb | input | 4 | Byte-lane write strobes |
| req_wdata | input | 32 | Write data, placed in its byte lanes |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data, shifted down to bit 0 |
| chan_done | input | 3 | Block-end pulses from the channel engines |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that chan_done bits are single-cycle pulses and that a write asserts only strobes lying inside its own size and alignment. The bench's write task builds its strobes from the size and the low address bits, and it returns chan_done to zero after one cycle. One case drives a pulse in the same cycle as an enable-dropping write, to show that the set wins over the clear. Paged accesses are issued only after the page write that precedes them has completed.

// File: rtl/audio_regbank_pkg.sv
package audio_regbank_pkg;

  typedef enum logic [3:0] {
    TGT_NONE,
    TGT_CTRL,
    TGT_STAT,
    TGT_PAGE,
    TGT_CODEC,
    TGT_SCTRL,
    TGT_SCNT,
    TGT_FRAME,
    TGT_PHANTOM,
    TGT_LEGACY
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [2:0] fidx;
    logic [1:0] sidx;
  } dec_t;

  localparam logic [31:0] CTRL_RESET   = 32'h0000_0001;
  localparam logic [31:0] STAT_FIXED   = 32'h0000_0060;
  localparam logic [31:0] LEGACY_VALUE = 32'h0000_0005;
  localparam int          IEN_LSB      = 8;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import audio_regbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  input  logic [1:0]        size,
  output dec_t              dec
);
  localparam int FULL_W = ADDR_W + PAGE_W;

  logic [FULL_W-1:0] full;

  always_comb begin
    full = {{PAGE_W{1'b0}}, addr};
    if (addr[ADDR_W-1:4] == (ADDR_W-4)'(3))
      full = {page, addr};
  end

  always_comb begin
    dec = '{tgt: TGT_NONE, fidx: 3'd0, sidx: 2'd0};
    case (full[FULL_W-1:2])
      (FULL_W-2)'('h000 >> 2): dec.tgt = TGT_CTRL;
      (FULL_W-2)'('h004 >> 2): dec.tgt = TGT_STAT;
      (FULL_W-2)'('h00C >> 2): dec.tgt = TGT_PAGE;
      (FULL_W-2)'('h010 >> 2): dec.tgt = TGT_CODEC;
      (FULL_W-2)'('h018 >> 2):
        if (size == 2'd0 && full[1:0] == 2'd3) dec.tgt = TGT_LEGACY;
      (FULL_W-2)'('h020 >> 2): dec.tgt = TGT_SCTRL;
      (FULL_W-2)'('h024 >> 2): begin dec.tgt = TGT_SCNT; dec.sidx = 2'd0; end
      (FULL_W-2)'('h028 >> 2): begin dec.tgt = TGT_SCNT; dec.sidx = 2'd1; end
      (FULL_W-2)'('h02C >> 2): begin dec.tgt = TGT_SCNT; dec.sidx = 2'd2; end
      (FULL_W-2)'('hC30 >> 2), (FULL_W-2)'('hC34 >> 2),
      (FULL_W-2)'('hC38 >> 2), (FULL_W-2)'('hC3C >> 2): begin
        dec.tgt  = TGT_FRAME;
        dec.fidx = {1'b0, full[3:2]};
      end
      (FULL_W-2)'('hD30 >> 2), (FULL_W-2)'('hD34 >> 2): begin
        dec.tgt  = TGT_FRAME;
        dec.fidx = 3'd4 + {2'b0, full[2]};
      end
      (FULL_W-2)'('hD38 >> 2), (FULL_W-2)'('hD3C >> 2): dec.tgt = TGT_PHANTOM;
      default: dec.tgt = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/regbank_frames.sv
module regbank_frames #(
  parameter int DATA_W  = 32,
  parameter int NFRAMES = 6,
  localparam int IDX_W  = $clog2(NFRAMES),
  localparam int NLANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [NLANES-1:0] strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] regs [NFRAMES];

  for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (we && widx == IDX_W'(g)) begin
        for (int l = 0; l < NLANES; l++)
          if (strb[l]) regs[g][l*8 +: 8] <= wdata[l*8 +: 8];
      end
    end
  end

  assign rdata = (int'(ridx) < NFRAMES) ? regs[ridx] : '1;
endmodule

// File: rtl/regbank_irq.sv
module regbank_irq #(
  parameter int NCHAN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCHAN-1:0] en,
  input  logic [NCHAN-1:0] en_nxt,
  input  logic             en_we,
  input  logic [NCHAN-1:0] done,
  output logic [NCHAN-1:0] pend,
  output logic             irq_o
);
  logic [NCHAN-1:0] drop, set, pend_n;

  always_comb begin
    drop   = en_we ? (en & ~en_nxt) : '0;
    set    = done & en;
    pend_n = (pend & ~drop) | set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      irq_o <= 1'b0;
    end else begin
      pend  <= pend_n;
      irq_o <= |pend_n;
    end
  end

  a_r6_irq_is_or: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|pend));

  for (genvar c = 0; c < NCHAN; c++) begin : g_chk
    a_r7_no_set_when_off: assert property (@(posedge clk) disable iff (rst)
      (!pend[c] && !(done[c] && en[c])) |=> !pend[c]);
    a_r8_drop_clears: assert property (@(posedge clk) disable iff (rst)
      (en_we && en[c] && !en_nxt[c] && !done[c]) |=> !pend[c]);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
      (done[c] && en[c]) |=> pend[c]);
  end
endmodule

// File: rtl/audio_regbank.sv
module audio_regbank
  import audio_regbank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PAGE_W  = 4,
  parameter int NCHAN   = 3,
  parameter int NFRAMES = 6,
  parameter int SCNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [3:0]        req_strb,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  input  logic [NCHAN-1:0]  chan_done,
  output logic              irq_o
);
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(NFRAMES);

  logic [DATA_W-1:0] ctrl, codec, sctrl, sctrl_n, bmask, fr_rdata, rword, shifted;
  logic [PAGE_W-1:0] page;
  logic [SCNT_W-1:0] scnt [NCHAN];
  logic [NCHAN-1:0]  pend, en_cur, en_new;
  dec_t              dec;
  logic              wr, rd, sc_we;

  assign req_ready = 1'b1;
  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  regbank_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) dec_i (
    .addr(req_addr), .page(page), .size(req_size), .dec(dec));

  for (genvar l = 0; l < 4; l++) begin : g_mask
    assign bmask[l*8 +: 8] = {8{req_strb[l]}};
  end

  assign sctrl_n = (sctrl & ~bmask) | (req_wdata & bmask);
  assign sc_we   = wr && dec.tgt == TGT_SCTRL;

  for (genvar c = 0; c < NCHAN; c++) begin : g_en
    assign en_cur[c] = sctrl[IEN_LSB + NCHAN - 1 - c];
    assign en_new[c] = sctrl_n[IEN_LSB + NCHAN - 1 - c];
  end

  regbank_irq #(.NCHAN(NCHAN)) irq_i (
    .clk(clk), .rst(rst), .en(en_cur), .en_nxt(en_new), .en_we(sc_we),
    .done(chan_done), .pend(pend), .irq_o(irq_o));

  regbank_frames #(.DATA_W(DATA_W), .NFRAMES(NFRAMES)) fr_i (
    .clk(clk), .rst(rst), .we(wr && dec.tgt == TGT_FRAME),
    .widx(dec.fidx[IDX_W-1:0]), .strb(req_strb), .wdata(req_wdata),
    .ridx(dec.fidx[IDX_W-1:0]), .rdata(fr_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= CTRL_RESET;
      codec <= '0;
      sctrl <= '0;
      page  <= '0;
      for (int c = 0; c < NCHAN; c++) scnt[c] <= '0;
    end else if (wr) begin
      case (dec.tgt)
        TGT_CTRL:  ctrl  <= (ctrl & ~bmask) | (req_wdata & bmask);
        TGT_CODEC: codec <= (codec & ~bmask) | (req_wdata & bmask);
        TGT_SCTRL: sctrl <= sctrl_n;
        TGT_PAGE:  if (req_strb[0]) page <= req_wdata[PAGE_W-1:0];
        TGT_SCNT:
          for (int c = 0; c < NCHAN; c++)
            if (dec.sidx == 2'(c))
              for (int l = 0; l < SCNT_W/8; l++)
                if (req_strb[l]) scnt[c][l*8 +: 8] <= req_wdata[l*8 +: 8];
        default: ;
      endcase
    end
  end

  always_comb begin
    rword = '1;
    case (dec.tgt)
      TGT_CTRL:   rword = ctrl;
      TGT_STAT:   rword = {|pend, STAT_FIXED[30:NCHAN], pend};
      TGT_PAGE:   rword = DATA_W'(page);
      TGT_CODEC:  rword = codec;
      TGT_SCTRL:  rword = sctrl;
      TGT_SCNT:   rword = DATA_W'(scnt[dec.sidx]);
      TGT_FRAME:  rword = fr_rdata;
      default:    rword = '1;
    endcase
    shifted = rword >> {req_addr[1:0], 3'b000};
    case (req_size)
      2'd0:    shifted = shifted & 32'h0000_00FF;
      2'd1:    shifted = shifted & 32'h0000_FFFF;
      default: ;
    endcase
    if (dec.tgt == TGT_LEGACY)
      shifted = LEGACY_VALUE;
    else if (dec.tgt == TGT_NONE || dec.tgt == TGT_PHANTOM)
      shifted = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= shifted;
    end
  end

  a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
    rd |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rsp_valid);
  a_r3_page_stable: assert property (@(posedge clk) disable iff (rst)
    !(wr && dec.tgt == TGT_PAGE) |=> $stable(page));
  a_r6_status_irq: assert property (@(posedge clk) disable iff (rst)
    irq_o == (pend != '0));
endmodule

// File: tb/audio_regbank_tb_top.sv
module audio_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [3:0]  req_strb = '0;
  logic [31:0] req_wdata = '0;
  logic [2:0]  chan_done = '0;
  logic        req_ready, rsp_valid, irq_o;
  logic [31:0] rsp_data;

  int checks = 0, fails = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_regbank dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_strb(req_strb), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .chan_done(chan_done), .irq_o(irq_o));

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected response act=%h exp=none", rsp_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rsp_data !== e) begin
          fails++;
          $display("FAIL %s act=%h exp=%h", t, rsp_data, e);
        end
      end
    end
  end

  function automatic logic [3:0] lanes(input logic [1:0] sz, input logic [7:0] a);
    case (sz)
      2'd0:    return 4'b0001 << a[1:0];
      2'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [1:0] sz,
                    input logic [31:0] d, input logic [2:0] pulse = 3'b000);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz;
    req_strb = lanes(sz, a); req_wdata = d << {a[1:0], 3'b000};
    chan_done = pulse;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_strb = '0; chan_done = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] sz,
                    input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    req_strb = '0;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] p);
    @(negedge clk); chan_done = p;
    @(negedge clk); chan_done = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq_o !== e) begin
      fails++;
      $display("FAIL %s irq act=%b exp=%b", t, irq_o, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    rd(8'h00, 2'd2, 32'h0000_0001, "R1 ctrl");
    rd(8'h04, 2'd2, 32'h0000_0060, "R1 status");
    rd(8'h0C, 2'd2, 32'h0, "R1 page");
    rd(8'h10, 2'd2, 32'h0, "R1 codec");
    rd(8'h20, 2'd2, 32'h0, "R1 sctrl");
    chk_irq(1'b0, "R1 irq");
    // R2 lane merges
    wr(8'h02, 2'd0, 32'hAB);
    rd(8'h00, 2'd2, 32'h00AB_0001, "R2 ctrl byte");
    wr(8'h02, 2'd1, 32'h1234);
    rd(8'h00, 2'd2, 32'h1234_0001, "R2 ctrl half");
    rd(8'h03, 2'd0, 32'h12, "R10 byte read");
    rd(8'h02, 2'd1, 32'h1234, "R10 half read");
    rd(8'h00, 2'd0, 32'h01, "R10 byte mask");
    wr(8'h21, 2'd0, 32'h07);
    wr(8'h20, 2'd0, 32'h5A);
    rd(8'h20, 2'd2, 32'h0000_075A, "R2 sctrl merge");
    // R3 page width
    wr(8'h0C, 2'd2, 32'hFFFF_FFFF);
    rd(8'h0C, 2'd2, 32'h0000_000F, "R3 page");
    rd(8'h30, 2'd2, 32'hFFFF_FFFF, "R4 page F");
    // R4 paged frames
    wr(8'h0C, 2'd2, 32'hC);
    wr(8'h30, 2'd2, 32'h1111_1111);
    wr(8'h34, 2'd2, 32'h2222_2222);
    wr(8'h38, 2'd2, 32'h3333_3333);
    wr(8'h3C, 2'd2, 32'h4444_4444);
    wr(8'h0C, 2'd2, 32'hD);
    wr(8'h30, 2'd2, 32'h5555_5555);
    wr(8'h34, 2'd2, 32'h6666_6666);
    wr(8'h38, 2'd2, 32'h7777_7777);
    rd(8'h30, 2'd2, 32'h5555_5555, "R4 rec addr");
    rd(8'h34, 2'd2, 32'h6666_6666, "R4 rec count");
    rd(8'h38, 2'd2, 32'hFFFF_FFFF, "R4 phantom");
    wr(8'h0C, 2'd2, 32'hC);
    rd(8'h30, 2'd2, 32'h1111_1111, "R4 p1 addr");
    rd(8'h38, 2'd2, 32'h3333_3333, "R4 p2 addr");
    rd(8'h3E, 2'd1, 32'h4444, "R4 p2 count half");
    wr(8'h0C, 2'd2, 32'h0);
    rd(8'h30, 2'd2, 32'hFFFF_FFFF, "R4 page 0");
    // R5 undecoded and legacy
    rd(8'h18, 2'd2, 32'hFFFF_FFFF, "R5 undecoded");
    rd(8'h1B, 2'd0, 32'h5, "R5 legacy byte");
    rd(8'h40, 2'd2, 32'hFFFF_FFFF, "R5 high offset");
    // R9 sample count
    wr(8'h28, 2'd2, 32'hABCD_1234);
    rd(8'h28, 2'd2, 32'h0000_1234, "R9 scount");
    rd(8'h24, 2'd2, 32'h0, "R9 other scount");
    // R6 R7 pending
    wr(8'h20, 2'd2, 32'h0000_0500);
    pulse(3'b010);
    chk_irq(1'b0, "R7 disabled p2");
    rd(8'h04, 2'd2, 32'h0000_0060, "R7 status p2 off");
    pulse(3'b100);
    chk_irq(1'b1, "R6 irq p1");
    rd(8'h04, 2'd2, 32'h8000_0064, "R6 status p1");
    pulse(3'b001);
    rd(8'h04, 2'd2, 32'h8000_0065, "R6 status p1 rec");
    // R8 clear on drop, set wins
    wr(8'h20, 2'd2, 32'h0000_0400);
    rd(8'h04, 2'd2, 32'h8000_0061, "R8 drop p1");
    wr(8'h20, 2'd2, 32'h0, 3'b001);
    rd(8'h04, 2'd2, 32'h8000_0061, "R8 set wins");
    chk_irq(1'b1, "R8 irq held");
    wr(8'h20, 2'd2, 32'h0000_0400);
    wr(8'h20, 2'd2, 32'h0);
    rd(8'h04, 2'd2, 32'h0000_0060, "R8 drop rec");
    chk_irq(1'b0, "R6 irq low");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing responses act=%0d exp=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule